// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block keeps the three system-control registers of a 32-bit core: a status word with a three-level mode stack in its low six bits, a cause word, and the saved exception PC. When the pipeline raises a fault it gives a cause code, the address of the faulting instruction and a flag that says whether that instruction sat in a branch delay slot. On the next clock edge the block records the cause, saves the return address, pushes the mode stack and steers fetch to the handler vector. A return strobe pops the mode stack.

Software reaches the registers through a plain indexed read port, which is combinational, and a write port, which only loads the status register. The fetch-PC and next-PC outputs hold their value until reset or an exception moves them. All control pins are plain level or pulse signals with no handshake. Each request is taken on the edge where it is sampled.

Top module: `cp0_exc_ctrl`

## Requirements
- R1: After reset, fetch_pc is 0xBFC00000, next_pc is 0xBFC00004, and status, cause and saved PC all read zero.
- R2: On an exception, cause becomes the 5-bit code placed in bits 6:2. Bits 30:7 and 1:0 are zero, and bit 31 is the delay-slot flag.
- R3: On an exception, the saved PC is fault_pc. When in_delay_slot is 1 it is fault_pc minus 4 instead, and cause bit 31 is set.
- R4: On an exception, fetch_pc becomes 0xBFC00180 if status bit 22 is 1 and 0x80000080 otherwise, and next_pc becomes fetch_pc plus 4.
- R5: On an exception, status bits 5:0 become (old bits 5:0 shifted left by 2) masked to 6 bits. Status bits 31:6 are unchanged.
- R6: On a return strobe, status bits 5:0 become the old bits 5:0 shifted right by 2. Status bits 31:6 are unchanged.
- R7: rd_data returns status for index 12, cause for index 13 and saved PC for index 14, in the same cycle. Every other index returns zero.
- R8: A write to index 12 loads the full status word on the next edge. A write to any other index, including 13 and 14, changes nothing.
- R9: When requests arrive in the same cycle, an exception beats a return strobe, and a return strobe beats a status write. The losing requests are dropped.
- R10: fetch_pc and next_pc change only on reset or an exception, and every register update shows one clock after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request, one-cycle pulse |
| exc_code | input | 5 | Cause code of the exception |
| fault_pc | input | 32 | Address of the faulting instruction |
| in_delay_slot | input | 1 | Faulting instruction is in a branch delay slot |
| rfe | input | 1 | Return-from-exception strobe |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Register write index |
| wr_data | input | 32 | Register write data |
| rd_idx | input | 5 | Register read index |
| rd_data | output | 32 | Register read data |
| fetch_pc | output | 32 | Redirected fetch address |
| next_pc | output | 32 | Address after fetch_pc |

## Verification
Directed exceptions are raised with both settings of status bit 22. This separates the two handler vectors and checks that next_pc is always four beyond fetch_pc. Faults inside and outside a delay slot separate the adjusted saved PC from the plain one and show whether the cause flag follows. Chains of exceptions and returns over several mode patterns confirm that the stack shifts by two and that a push drops the oldest level. Same-cycle collisions of exception, return and status write, followed by a long random run, test the priority order against the bench model on every clock.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
  localparam int XLEN = 32;
  localparam int IDX_W = 5;
  localparam int CODE_W = 5;
  localparam int MODE_W = 6;
  localparam int BEV_BIT = 22;
  localparam logic [IDX_W-1:0] IDX_STATUS = 5'd12;
  localparam logic [IDX_W-1:0] IDX_CAUSE = 5'd13;
  localparam logic [IDX_W-1:0] IDX_EPC = 5'd14;
  localparam logic [XLEN-1:0] RESET_PC = 32'hBFC0_0000;
  localparam logic [XLEN-1:0] BOOT_VEC = 32'hBFC0_0180;
  localparam logic [XLEN-1:0] NORM_VEC = 32'h8000_0080;

  typedef enum logic [CODE_W-1:0] {
    EXC_LOAD_ADDR  = 5'h04,
    EXC_STORE_ADDR = 5'h05,
    EXC_SYSCALL    = 5'h08,
    EXC_BREAK      = 5'h09,
    EXC_ILLEGAL    = 5'h0A,
    EXC_COP_UNUSE  = 5'h0B,
    EXC_OVERFLOW   = 5'h0C
  } exc_code_e;
endpackage

// File: rtl/cp0_status.sv
module cp0_status
  import cp0_pkg::*;
#(
  parameter int W = XLEN,
  parameter int MW = MODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] sr
);
  localparam int STEP = 2;

  logic [MW-1:0] mode_q;
  logic [W-1:MW] upper_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      upper_q <= '0;
    end else if (push) begin
      mode_q  <= mode_q << STEP;
    end else if (pop) begin
      mode_q  <= mode_q >> STEP;
    end else if (wr_en) begin
      mode_q  <= wr_data[MW-1:0];
      upper_q <= wr_data[W-1:MW];
    end
  end

  assign sr = {upper_q, mode_q};

  assert_push_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (sr[MW-1:0] == MW'($past(sr[MW-1:0]) << STEP)) && (sr[W-1:MW] == $past(sr[W-1:MW])));
  assert_pop_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (sr[MW-1:0] == ($past(sr[MW-1:0]) >> STEP)) && $stable(sr[W-1:MW]));
  assert_write_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop && !wr_en) |=> $stable(sr));
endmodule

// File: rtl/cp0_cause_epc.sv
module cp0_cause_epc
  import cp0_pkg::*;
#(
  parameter int W = XLEN,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [CW-1:0] code,
  input  logic [W-1:0]  fault_pc,
  input  logic          in_ds,
  output logic [W-1:0]  cause,
  output logic [W-1:0]  epc
);
  localparam int CODE_LSB = 2;
  localparam int PAD_W = W - 1 - CW - CODE_LSB;
  localparam logic [W-1:0] SLOT_BYTES = W'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause <= '0;
      epc   <= '0;
    end else if (take) begin
      cause <= {in_ds, {PAD_W{1'b0}}, code, {CODE_LSB{1'b0}}};
      epc   <= in_ds ? (fault_pc - SLOT_BYTES) : fault_pc;
    end
  end

  assert_cause_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cause[CODE_LSB-1:0] == '0) && (cause[W-2:CW+CODE_LSB] == '0) && (cause[CW+CODE_LSB-1:CODE_LSB] == $past(code)));
  assert_epc_adjust_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_ds) |=> (epc + SLOT_BYTES == $past(fault_pc)) && cause[W-1]);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cause) && $stable(epc));
endmodule

// File: rtl/cp0_vector.sv
module cp0_vector
  import cp0_pkg::*;
#(
  parameter int W = XLEN,
  parameter logic [W-1:0] RST_PC = RESET_PC,
  parameter logic [W-1:0] VEC_BOOT = BOOT_VEC,
  parameter logic [W-1:0] VEC_NORM = NORM_VEC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         bev,
  output logic [W-1:0] fetch_pc,
  output logic [W-1:0] next_pc
);
  localparam logic [W-1:0] INSN_BYTES = W'(4);

  logic [W-1:0] target;
  assign target = bev ? VEC_BOOT : VEC_NORM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc <= RST_PC;
      next_pc  <= RST_PC + INSN_BYTES;
    end else if (take) begin
      fetch_pc <= target;
      next_pc  <= target + INSN_BYTES;
    end
  end

  assert_vector_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (next_pc == fetch_pc + INSN_BYTES) && (fetch_pc == ($past(bev) ? VEC_BOOT : VEC_NORM)));
  assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(fetch_pc) && $stable(next_pc));
endmodule

// File: rtl/cp0_exc_ctrl.sv
module cp0_exc_ctrl
  import cp0_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   fault_pc,
  input  logic              in_delay_slot,
  input  logic              rfe,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [XLEN-1:0]   rd_data,
  output logic [XLEN-1:0]   fetch_pc,
  output logic [XLEN-1:0]   next_pc
);
  logic [XLEN-1:0] sr, cause, epc;
  logic sr_wr;

  assign sr_wr = wr_en && (wr_idx == IDX_STATUS);

  cp0_status #(.W(XLEN), .MW(MODE_W)) u_status (
    .clk(clk), .rst_n(rst_n), .push(exc_req), .pop(rfe),
    .wr_en(sr_wr), .wr_data(wr_data), .sr(sr)
  );

  cp0_cause_epc #(.W(XLEN), .CW(CODE_W)) u_cause (
    .clk(clk), .rst_n(rst_n), .take(exc_req), .code(exc_code),
    .fault_pc(fault_pc), .in_ds(in_delay_slot), .cause(cause), .epc(epc)
  );

  cp0_vector #(.W(XLEN)) u_vec (
    .clk(clk), .rst_n(rst_n), .take(exc_req), .bev(sr[BEV_BIT]),
    .fetch_pc(fetch_pc), .next_pc(next_pc)
  );

  always_comb begin
    unique case (rd_idx)
      IDX_STATUS: rd_data = sr;
      IDX_CAUSE:  rd_data = cause;
      IDX_EPC:    rd_data = epc;
      default:    rd_data = '0;
    endcase
  end

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx != IDX_STATUS && rd_idx != IDX_CAUSE && rd_idx != IDX_EPC) |-> rd_data == '0);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> fetch_pc == RESET_PC && sr == '0 && cause == '0 && epc == '0);
endmodule

// File: tb/tb_cp0_exc_ctrl.sv
module tb_cp0_exc_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_req = 1'b0;
  logic [4:0] exc_code = '0;
  logic [31:0] fault_pc = '0;
  logic in_delay_slot = 1'b0;
  logic rfe = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0] rd_idx = '0;
  logic [31:0] rd_data, fetch_pc, next_pc;

  int checks = 0;
  int fails = 0;

  logic [31:0] m_sr, m_cause, m_epc, m_fpc, m_npc;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp0_exc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .fault_pc(fault_pc), .in_delay_slot(in_delay_slot), .rfe(rfe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
    .rd_data(rd_data), .fetch_pc(fetch_pc), .next_pc(next_pc)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [4:0] idx);
    if (idx == 5'd12) return m_sr;
    if (idx == 5'd13) return m_cause;
    if (idx == 5'd14) return m_epc;
    return 32'h0;
  endfunction

  task automatic model_edge();
    logic [31:0] vec;
    if (!rst_n) begin
      m_sr = 0; m_cause = 0; m_epc = 0; m_fpc = 32'hBFC00000; m_npc = 32'hBFC00004;
    end else if (exc_req) begin
      vec = m_sr[22] ? 32'hBFC00180 : 32'h80000080;
      m_fpc = vec;
      m_npc = vec + 4;
      m_cause = {27'd0, exc_code} * 4 + (in_delay_slot ? 32'h80000000 : 32'h0);
      m_epc = in_delay_slot ? fault_pc - 4 : fault_pc;
      m_sr = {m_sr[31:6], 6'((m_sr[5:0] * 4) % 64)};
    end else if (rfe) begin
      m_sr = {m_sr[31:6], 6'(m_sr[5:0] / 4)};
    end else if (wr_en && wr_idx == 5'd12) begin
      m_sr = wr_data;
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "fetch_pc", fetch_pc, m_fpc);
    chk(tag, "next_pc", next_pc, m_npc);
    chk(tag, "rd_data", rd_data, m_read(rd_idx));
  endtask

  task automatic clear();
    exc_req = 0; rfe = 0; wr_en = 0; in_delay_slot = 0;
  endtask

  task automatic rd(input logic [4:0] idx, input string tag);
    rd_idx = idx;
    #1;
    chk(tag, "read", rd_data, m_read(idx));
  endtask

  task automatic raise(input logic [4:0] code, input logic [31:0] pc, input logic ds, input string tag);
    exc_req = 1; exc_code = code; fault_pc = pc; in_delay_slot = ds;
    step(tag);
    clear();
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] d, input string tag);
    wr_en = 1; wr_idx = idx; wr_data = d;
    step(tag);
    clear();
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0;
    step("R1");
    step("R1");
    rst_n = 1;
    step("R1");
    rd(5'd12, "R1"); rd(5'd13, "R1"); rd(5'd14, "R1");
    chk("R1", "fetch_pc", fetch_pc, 32'hBFC00000);
    chk("R1", "next_pc", next_pc, 32'hBFC00004);

    // R8: status write, writes to 13/14 ignored
    rd_idx = 5'd12;
    wr(5'd12, 32'h0000_0015, "R8");
    chk("R8", "status", rd_data, 32'h0000_0015);
    wr(5'd13, 32'hFFFF_FFFF, "R8");
    rd(5'd13, "R8");
    chk("R8", "cause", rd_data, 32'h0);
    wr(5'd14, 32'h1234_5678, "R8");
    rd(5'd14, "R8");

    // R2/R4/R5: plain exception with bit 22 clear
    raise(5'h08, 32'h8000_1000, 0, "R4");
    chk("R4", "fetch_pc", fetch_pc, 32'h80000080);
    rd(5'd13, "R2");
    chk("R2", "cause", rd_data, 32'h0000_0020);
    rd(5'd14, "R3");
    chk("R3", "epc", rd_data, 32'h8000_1000);
    rd(5'd12, "R5");
    chk("R5", "status", rd_data, 32'h0000_0014);

    // R6: return pops
    rfe = 1; step("R6"); clear();
    chk("R6", "status", rd_data, 32'h0000_0005);

    // R3: delay slot
    raise(5'h0C, 32'h8000_2004, 1, "R3");
    rd(5'd14, "R3");
    chk("R3", "epc", rd_data, 32'h8000_2000);
    rd(5'd13, "R3");
    chk("R3", "cause", rd_data, 32'h8000_0030);

    // R4: boot vector
    wr(5'd12, 32'h0040_003F, "R4");
    raise(5'h04, 32'h0000_0100, 0, "R4");
    chk("R4", "fetch_pc", fetch_pc, 32'hBFC00180);
    chk("R4", "next_pc", next_pc, 32'hBFC00184);
    rd(5'd12, "R5");
    chk("R5", "status", rd_data, 32'h0040_003C);

    // R9: exception + return + write together
    exc_req = 1; exc_code = 5'h09; fault_pc = 32'h0000_0200; rfe = 1;
    wr_en = 1; wr_idx = 5'd12; wr_data = 32'h0;
    step("R9"); clear();
    rd(5'd12, "R9");
    chk("R9", "status", rd_data, 32'h0040_0030);
    rfe = 1; wr_en = 1; wr_idx = 5'd12; wr_data = 32'hAAAA_AAAA;
    step("R9"); clear();
    chk("R9", "status", rd_data, 32'h0040_000C);

    // R10: idle holds; R7: unmapped reads
    rd_idx = 5'd0;
    repeat (4) step("R10");
    chk("R10", "fetch_pc", fetch_pc, 32'hBFC00180);
    rd(5'd0, "R7"); rd(5'd15, "R7"); rd(5'd31, "R7"); rd(5'd11, "R7");

    // random run against the model
    for (int i = 0; i < 400; i++) begin
      exc_req = ($urandom % 5) == 0;
      exc_code = 5'($urandom);
      fault_pc = $urandom;
      in_delay_slot = 1'($urandom);
      rfe = ($urandom % 4) == 0;
      wr_en = ($urandom % 3) == 0;
      wr_idx = ($urandom % 2) ? 5'd12 : 5'($urandom);
      wr_data = $urandom;
      rd_idx = 5'(11 + $urandom % 5);
      step("R9");
    end
    clear();
    step("R10");

    summary();
    $finish;
  end
endmodule